// File: doc/BRIEF.md
# Block-Protocol Frame Parser with Payload Reassembly

This block sits behind a smartcard byte receiver running the half-duplex block-oriented transmission protocol. It takes one received byte per accepted cycle and walks each frame through its fields: an address byte, a control byte, a length byte, as many information bytes as the length gives, and a closing redundancy byte. For each frame it reports the block kind, the two three-bit node addresses and whether the longitudinal redundancy check came out clean.

Payload bytes from information blocks go to a simple downstream byte interface, one byte per valid pulse and in arrival order. Receive-ready and supervisory blocks are classified and reported but never produce payload. When an information block sets its more-data flag, the message continues in the next information block. The parser keeps a chain-open indication and pulses a message-done output only when an information block with the flag clear closes the message. Control blocks that arrive inside an open chain do not close it.

Top module: `frm_parser`

## Requirements
- R1: Frames are parsed as address byte, control byte, length byte, then length information bytes, then one redundancy byte. A length of zero moves straight from the length byte to the redundancy byte. `blk_done` pulses for exactly one cycle, in the cycle after the redundancy byte is accepted.
- R2: With `blk_done`, `src_addr` shows bits 6:4 of the frame's address byte and `dst_addr` shows bits 2:0.
- R3: With `blk_done`, `blk_kind` is 0 (information) when control bit 7 is 0, 1 (receive-ready) when control bits 7:6 are 10, and 2 (supervisory) when they are 11. The value 3 never appears.
- R4: With `blk_done`, `lrc_err` is 1 exactly when the XOR of every byte of the frame, the redundancy byte included, is nonzero. The flag holds its value until the next `blk_done`.
- R5: Each information byte of an information block is sent out on `pay_byte` with a one-cycle `pay_valid`, in the cycle after it is accepted and in the order received. Other block kinds and the non-information fields produce no payload.
- R6: An information block with control bit 5 (more-data) set raises `chain_open` in its `blk_done` cycle and gives no `msg_done`.
- R7: An information block with control bit 5 clear pulses `msg_done` together with its `blk_done` and clears `chain_open`. Payload across a chain comes out as one continuous byte sequence.
- R8: A receive-ready or supervisory block completed while a chain is open leaves `chain_open` set and gives no `msg_done`.
- R9: After reset, `pay_valid`, `blk_done`, `msg_done`, `chain_open` and `lrc_err` are 0, and the parser expects an address byte.
- R10: Cycles with `in_valid` low do not advance the parser or change the redundancy sum. Idle gaps between bytes give the same results as a back-to-back stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received byte is present on `in_byte` |
| in_byte | input | 8 | Received byte |
| pay_valid | output | 1 | Payload byte strobe |
| pay_byte | output | 8 | Payload byte |
| blk_done | output | 1 | One-cycle pulse at the end of each block |
| blk_kind | output | 2 | Block kind: 0 info, 1 receive-ready, 2 supervisory |
| lrc_err | output | 1 | Redundancy mismatch of the last completed block |
| msg_done | output | 1 | Pulse when an information block ends a message |
| chain_open | output | 1 | A message is continuing in a following information block |
| src_addr | output | 3 | Source address of the last completed block |
| dst_addr | output | 3 | Destination address of the last completed block |

## Verification
The parser is driven with information blocks of several lengths including zero, with receive-ready and supervisory blocks that carry data bytes, and with a frame whose redundancy byte is corrupted. Together these separate correct field counting and payload gating from classification and checksum handling. A three-block chain with a receive-ready block in the middle tests that more-data concatenation and chain closing depend on the kind of each block. A repeat of one frame with idle cycles between its bytes tests that only accepted bytes advance the parser.

// File: rtl/frm_pkg.sv
package frm_pkg;

   typedef enum logic [2:0] {
      FS_ADDR = 3'd0,
      FS_CTRL = 3'd1,
      FS_LEN  = 3'd2,
      FS_INFO = 3'd3,
      FS_SUM  = 3'd4
   } fld_e;

   typedef enum logic [1:0] {
      BK_INFO = 2'd0,
      BK_RDY  = 2'd1,
      BK_SUP  = 2'd2
   } blk_e;

   // ctl holds control bits 7:5
   function automatic blk_e classify(input logic [2:0] ctl);
      if (!ctl[2])     return BK_INFO;
      else if (ctl[1]) return BK_SUP;
      else             return BK_RDY;
   endfunction

endpackage

// File: rtl/frm_field_seq.sv
module frm_field_seq
   import frm_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output fld_e              fld
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld    <= FS_ADDR;
         remain <= '0;
      end else if (in_valid) begin
         unique case (fld)
            FS_ADDR: fld <= FS_CTRL;
            FS_CTRL: fld <= FS_LEN;
            FS_LEN: begin
               remain <= in_byte[LEN_W-1:0];
               fld    <= (in_byte[LEN_W-1:0] == '0) ? FS_SUM : FS_INFO;
            end
            FS_INFO: begin
               remain <= remain - ONE;
               if (remain == ONE) fld <= FS_SUM;
            end
            FS_SUM:  fld <= FS_ADDR;
            default: fld <= FS_ADDR;
         endcase
      end
   end

endmodule

// File: rtl/frm_lrc_acc.sv
module frm_lrc_acc #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              first,
   input  logic [BYTE_W-1:0] din,
   output logic              bad
);
   logic [BYTE_W-1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (take)  acc <= first ? din : (acc ^ din);
   end

   // meaningful while din is the closing byte
   assign bad = |(acc ^ din);

endmodule

// File: rtl/frm_chain_trk.sv
module frm_chain_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic close_blk,
   input  logic is_info,
   input  logic more,
   output logic open
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      open <= 1'b0;
      else if (close_blk && is_info)   open <= more;
   end
endmodule

// File: rtl/frm_parser.sv
module frm_parser
   import frm_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int LEN_W   = 8,
   parameter bit PAY_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              pay_valid,
   output logic [BYTE_W-1:0] pay_byte,
   output logic              blk_done,
   output logic [1:0]        blk_kind,
   output logic              lrc_err,
   output logic              msg_done,
   output logic              chain_open,
   output logic [2:0]        src_addr,
   output logic [2:0]        dst_addr
);
   localparam int SRC_LSB = 4;
   localparam int CTL_LSB = BYTE_W - 3;

   if (BYTE_W != 8) begin : g_bad_byte_w
      $error("frm_parser: BYTE_W must be 8");
   end
   if (LEN_W < 1 || LEN_W > BYTE_W) begin : g_bad_len_w
      $error("frm_parser: LEN_W must be 1..BYTE_W");
   end

   fld_e fld;
   logic at_addr, at_ctrl, at_info, at_sum;
   logic sum_bad;
   logic [2:0] src_q, dst_q, ctl_q;
   logic info_blk;
   blk_e kind;

   frm_field_seq #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .fld(fld)
   );

   assign at_addr = in_valid && (fld == FS_ADDR);
   assign at_ctrl = in_valid && (fld == FS_CTRL);
   assign at_info = in_valid && (fld == FS_INFO);
   assign at_sum  = in_valid && (fld == FS_SUM);

   frm_lrc_acc #(.BYTE_W(BYTE_W)) u_lrc (
      .clk(clk), .rst_n(rst_n), .take(in_valid), .first(at_addr),
      .din(in_byte), .bad(sum_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         ctl_q <= '0;
      end else begin
         if (at_addr) begin
            src_q <= in_byte[SRC_LSB+2:SRC_LSB];
            dst_q <= in_byte[2:0];
         end
         if (at_ctrl) ctl_q <= in_byte[BYTE_W-1:CTL_LSB];
      end
   end

   assign kind     = classify(ctl_q);
   assign info_blk = (kind == BK_INFO);

   frm_chain_trk u_chain (
      .clk(clk), .rst_n(rst_n), .close_blk(at_sum), .is_info(info_blk),
      .more(ctl_q[0]), .open(chain_open)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_done <= 1'b0;
         msg_done <= 1'b0;
         blk_kind <= 2'd0;
         lrc_err  <= 1'b0;
         src_addr <= '0;
         dst_addr <= '0;
      end else begin
         blk_done <= at_sum;
         msg_done <= at_sum && info_blk && !ctl_q[0];
         if (at_sum) begin
            blk_kind <= kind;
            lrc_err  <= sum_bad;
            src_addr <= src_q;
            dst_addr <= dst_q;
         end
      end
   end

   if (PAY_REG) begin : g_pay_reg
      logic              pv_q;
      logic [BYTE_W-1:0] pb_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pv_q <= 1'b0;
            pb_q <= '0;
         end else begin
            pv_q <= at_info && info_blk;
            if (at_info && info_blk) pb_q <= in_byte;
         end
      end
      assign pay_valid = pv_q;
      assign pay_byte  = pb_q;
   end else begin : g_pay_comb
      assign pay_valid = at_info && info_blk;
      assign pay_byte  = in_byte;
   end

endmodule

// File: rtl/frm_parser_chk.sv
module frm_parser_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pay_valid,
   input logic       blk_done,
   input logic [1:0] blk_kind,
   input logic       lrc_err,
   input logic       msg_done,
   input logic       chain_open
);
   // R1
   done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done |=> !blk_done);

   // R3
   kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done |-> (blk_kind != 2'd3));

   // R4
   lrc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_done |-> $stable(lrc_err));

   // R5
   pay_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |-> !blk_done);

   // R6
   chain_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chain_open) |-> (blk_done && blk_kind == 2'd0 && !msg_done));

   // R7
   msg_info_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_done |-> (blk_done && blk_kind == 2'd0 && !chain_open));

   // R8
   chain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_done && blk_kind != 2'd0) |-> ($stable(chain_open) && !msg_done));
endmodule

bind frm_parser frm_parser_chk u_chk (.*);

// File: tb/frm_parser_test.sv
`timescale 1ns/1ps
module frm_parser_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       pay_valid, blk_done, lrc_err, msg_done, chain_open;
   logic [7:0] pay_byte;
   logic [1:0] blk_kind;
   logic [2:0] src_addr, dst_addr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] exp_buf [0:63];
   logic [7:0] got_buf [0:63];
   int exp_n = 0, got_n = 0, msg_n = 0, done_n = 0;

   always #2.5 clk = ~clk;

   frm_parser uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .pay_valid(pay_valid), .pay_byte(pay_byte), .blk_done(blk_done),
      .blk_kind(blk_kind), .lrc_err(lrc_err), .msg_done(msg_done),
      .chain_open(chain_open), .src_addr(src_addr), .dst_addr(dst_addr)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (pay_valid) begin
            if (got_n < 64) got_buf[got_n] = pay_byte;
            got_n = got_n + 1;
         end
         if (msg_done) msg_n = msg_n + 1;
         if (blk_done) done_n = done_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b, input bit gaps);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'hEE;
      if (gaps) repeat (2) @(negedge clk);
   endtask

   task automatic send_block(input logic [7:0] nad, input logic [7:0] pcb,
                             input logic [7:0] len, input logic [7:0] seed,
                             input bit bad, input bit gaps);
      logic [7:0] sum;
      sum = nad ^ pcb ^ len;
      put(nad, gaps);
      put(pcb, gaps);
      put(len, gaps);
      for (int i = 0; i < len; i++) begin
         logic [7:0] d;
         d = seed + 8'(i * 7);
         sum = sum ^ d;
         if (!pcb[7]) begin
            exp_buf[exp_n] = d;
            exp_n++;
         end
         put(d, gaps);
      end
      if (gaps) begin
         in_valid = 1'b1;
         in_byte  = bad ? (sum ^ 8'h5A) : sum;
         @(negedge clk);
         in_valid = 1'b0;
      end else begin
         put(bad ? (sum ^ 8'h5A) : sum, 1'b0);
      end
      #1;
   endtask

   task automatic clear_counts();
      exp_n = 0; got_n = 0; msg_n = 0; done_n = 0;
   endtask

   task automatic cmp_pay(input string req);
      chk(got_n == exp_n, req, "payload count", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++)
         chk(got_buf[i] == exp_buf[i], req, "payload byte", got_buf[i], exp_buf[i]);
   endtask

   task automatic t_reset();
      #1;
      chk(!pay_valid && !blk_done && !msg_done, "R9", "strobes after reset",
          {pay_valid, blk_done, msg_done}, 0);
      chk(!chain_open && !lrc_err, "R9", "flags after reset", {chain_open, lrc_err}, 0);
      @(negedge clk);
   endtask

   task automatic t_info_single();
      clear_counts();
      send_block(8'h5B, 8'h00, 8'd3, 8'h10, 1'b0, 1'b0);
      chk(blk_done == 1'b1, "R1", "done after checksum byte", blk_done, 1);
      chk(blk_kind == 2'd0, "R3", "info kind", blk_kind, 0);
      chk(src_addr == 3'd5 && dst_addr == 3'd3, "R2", "addresses 5/3",
          {src_addr, dst_addr}, {3'd5, 3'd3});
      chk(lrc_err == 1'b0, "R4", "good checksum", lrc_err, 0);
      chk(msg_n == 1, "R7", "message done count", msg_n, 1);
      cmp_pay("R5");
      @(negedge clk); #1;
      chk(blk_done == 1'b0, "R1", "done is one cycle", blk_done, 0);
   endtask

   task automatic t_zero_len();
      clear_counts();
      send_block(8'h27, 8'h40, 8'd0, 8'h00, 1'b0, 1'b0);
      chk(blk_done == 1'b1 && done_n == 1, "R1", "zero length ends after 4 bytes", done_n, 1);
      chk(src_addr == 3'd2 && dst_addr == 3'd7, "R2", "addresses 2/7",
          {src_addr, dst_addr}, {3'd2, 3'd7});
      chk(got_n == 0, "R1", "no payload for zero length", got_n, 0);
      chk(msg_n == 1, "R7", "zero length info ends message", msg_n, 1);
      @(negedge clk);
   endtask

   task automatic t_ctrl_blocks();
      clear_counts();
      send_block(8'h12, 8'h92, 8'd2, 8'h33, 1'b0, 1'b0);
      chk(blk_kind == 2'd1, "R3", "receive-ready kind", blk_kind, 1);
      chk(got_n == 0, "R5", "no payload from receive-ready", got_n, 0);
      chk(msg_n == 0, "R8", "no message done on receive-ready", msg_n, 0);
      @(negedge clk);
      send_block(8'h01, 8'hC1, 8'd1, 8'h44, 1'b0, 1'b0);
      chk(blk_kind == 2'd2, "R3", "supervisory kind", blk_kind, 2);
      chk(got_n == 0, "R5", "no payload from supervisory", got_n, 0);
      chk(lrc_err == 1'b0, "R4", "good checksum supervisory", lrc_err, 0);
      @(negedge clk);
   endtask

   task automatic t_bad_sum();
      clear_counts();
      send_block(8'h00, 8'h00, 8'd2, 8'h80, 1'b1, 1'b0);
      chk(lrc_err == 1'b1, "R4", "corrupted checksum flagged", lrc_err, 1);
      repeat (3) @(negedge clk);
      #1;
      chk(lrc_err == 1'b1, "R4", "error held while idle", lrc_err, 1);
      send_block(8'h00, 8'h00, 8'd1, 8'h90, 1'b0, 1'b0);
      chk(lrc_err == 1'b0, "R4", "error cleared by good block", lrc_err, 0);
      @(negedge clk);
   endtask

   task automatic t_chain();
      clear_counts();
      send_block(8'h11, 8'h20, 8'd2, 8'hA0, 1'b0, 1'b0);
      chk(chain_open == 1'b1, "R6", "more flag opens chain", chain_open, 1);
      chk(msg_n == 0, "R6", "no message done mid chain", msg_n, 0);
      @(negedge clk);
      send_block(8'h11, 8'h80, 8'd0, 8'h00, 1'b0, 1'b0);
      chk(chain_open == 1'b1, "R8", "receive-ready keeps chain", chain_open, 1);
      chk(msg_n == 0, "R8", "receive-ready no message done", msg_n, 0);
      @(negedge clk);
      send_block(8'h11, 8'h40, 8'd3, 8'hB5, 1'b0, 1'b0);
      chk(msg_n == 1, "R7", "final block ends message", msg_n, 1);
      chk(chain_open == 1'b0, "R7", "chain closed", chain_open, 0);
      cmp_pay("R7");
      @(negedge clk);
   endtask

   task automatic t_gaps();
      clear_counts();
      send_block(8'h6C, 8'h00, 8'd4, 8'h21, 1'b0, 1'b1);
      chk(done_n == 1 && blk_done == 1'b1, "R10", "gapped frame completes once", done_n, 1);
      chk(lrc_err == 1'b0, "R10", "gapped checksum", lrc_err, 0);
      chk(src_addr == 3'd6 && dst_addr == 3'd4, "R10", "gapped addresses",
          {src_addr, dst_addr}, {3'd6, 3'd4});
      cmp_pay("R10");
      @(negedge clk);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_info_single();
      t_zero_len();
      t_ctrl_blocks();
      t_bad_sum();
      t_chain();
      t_gaps();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule